// File: doc/BRIEF.md
# Dual Prefetch Buffer Controller

This block sits between an instruction cache and a variable-length instruction decoder. It holds two line buffers of 32 bytes each. It asks the cache for aligned lines, keeps the buffers filled, and shows the decoder a window of up to 16 bytes that starts at the current read address. Each cycle the decoder says how many of the offered bytes it used, and the read address moves forward by that many bytes.

In straight-line code the two buffers take turns. The decoder reads from one buffer while the cache refills the other with the following line. When a branch is predicted taken, the spare buffer is used for the line at the predicted target. The current buffer keeps the sequential bytes that come before the branch. Reading then stops at the end of the current line until the prediction is resolved. A correct resolution moves the read address to the target. A wrong one throws the target line away and goes back to sequential fetching. A flush drops both buffers and starts again at a new address.

The cache handshake is plain request and valid. While `ic_req_o` is high, a cycle with `ic_valid_i` high returns the 32 bytes of the line at `ic_addr_o` in that same cycle.

Top module: `prefetch_dual_buf`

## Requirements
- R1: After reset, both buffers are empty. `dec_valid_o` is 0, `dec_mask_o` is 0, `dec_pc_o` equals `RESET_ADDR` (default 0), and `ic_req_o` is 1 with `ic_addr_o` set to the line holding `RESET_ADDR`.
- R2: `ic_req_o` is high whenever a buffer is empty, and `ic_addr_o` is then a 32-byte aligned line address. The buffer being read is requested before the spare one. A cycle with `ic_req_o` and `ic_valid_i` both high stores `ic_data_i`, whose bits 8k+7..8k are the byte at `ic_addr_o`+k. Once requested, `ic_req_o` stays high until it is served.
- R3: Byte i of `dec_bytes_o` (bits 8i+7..8i) is the instruction byte at `dec_pc_o`+i whenever bit i of `dec_mask_o` is set. The set mask bits always run contiguously from bit 0 upward. `dec_valid_o` equals mask bit 0.
- R4: Bytes past the end of the current line appear in the window only when the next line is already stored and no predicted target is pending.
- R5: A `dec_take_i` value no larger than the number of set mask bits advances `dec_pc_o` by that count in the next cycle. A larger value is ignored, and no byte is ever skipped or repeated.
- R6: When reading crosses into the spare buffer, the buffer just emptied is requested again for the line two lines past the one it held.
- R7: `br_taken_i`, when no target is pending, makes the spare buffer request the line of `br_target_i`. Reading continues in the current line up to its end, but not beyond it. `br_taken_i` while a target is pending is ignored.
- R8: `resolve_i` with `resolve_ok_i`=1 while a target is pending sets `dec_pc_o` to the saved target address in the next cycle. Fetching then continues sequentially from the target line.
- R9: `resolve_i` with `resolve_ok_i`=0 while a target is pending discards the target line. `dec_pc_o` keeps its value and the next sequential line is requested. `resolve_i` with no pending target has no effect.
- R10: `flush_i` sets `dec_pc_o` to `flush_addr_i` and clears the mask in the next cycle, and requests that address's line. It takes priority over a branch or a resolve in the same cycle.
- R11: Bytes consumed in the cycle a branch is accepted are still counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush_i | input | 1 | Restart the stream at flush_addr_i |
| flush_addr_i | input | ADDR_W | Restart byte address |
| br_taken_i | input | 1 | Predicted-taken branch seen |
| br_target_i | input | ADDR_W | Predicted target byte address |
| resolve_i | input | 1 | Prediction outcome valid |
| resolve_ok_i | input | 1 | 1 = prediction correct, 0 = wrong |
| ic_req_o | output | 1 | Line fetch request |
| ic_addr_o | output | ADDR_W | Aligned line address requested |
| ic_valid_i | input | 1 | Line data present for ic_addr_o |
| ic_data_i | input | LINE_BYTES*8 | Line data, byte k at bits 8k+7..8k |
| dec_bytes_o | output | WIN_BYTES*8 | Byte window for the decoder |
| dec_mask_o | output | WIN_BYTES | Per-byte valid bits |
| dec_valid_o | output | 1 | At least one byte is offered |
| dec_pc_o | output | ADDR_W | Address of window byte 0 |
| dec_take_i | input | $clog2(WIN_BYTES+1) | Bytes consumed this cycle |

## Verification
The bench first puts the window next to the end of a line while the next line is still missing. A design that joined the two buffers too early would show bytes that are wrong. It then drains the current line while a target is pending. A design that crossed into the target buffer at that point would hand the decoder target bytes as if they were sequential. Consume counts that are larger than what is offered, and consumption in the same cycle as a branch, test that the read address neither skips nor repeats a byte. A wrong resolution after the current line has been fully drained tests that the stream carries on with the very next sequential byte. Random runs check every offered byte against the value the cache model holds for its address.

// File: rtl/pfb_pkg.sv
package pfb_pkg;
  typedef logic [7:0] byte_t;
  typedef logic       slot_t;
  localparam slot_t SLOT_A = 1'b0;
endpackage

// File: rtl/pfb_store.sv
module pfb_store #(
  parameter int LINE_BYTES = 32
) (
  input  logic                              clk,
  input  logic                              we,
  input  pfb_pkg::slot_t                    wsel,
  input  logic [LINE_BYTES*8-1:0]           wdata,
  output logic [1:0][LINE_BYTES*8-1:0]      rdata
);
  for (genvar b = 0; b < 2; b++) begin : g_slot
    logic [LINE_BYTES*8-1:0] mem_q;
    always_ff @(posedge clk) begin
      if (we && (wsel == b[0])) mem_q <= wdata;
    end
    assign rdata[b] = mem_q;
  end
endmodule

// File: rtl/pfb_window.sv
module pfb_window #(
  parameter int LINE_BYTES = 32,
  parameter int WIN_BYTES  = 16,
  localparam int OFF_W  = $clog2(LINE_BYTES),
  localparam int PTR_W  = OFF_W + 1,
  localparam int TAKE_W = $clog2(WIN_BYTES + 1)
) (
  input  logic [1:0][LINE_BYTES*8-1:0] data_i,
  input  logic [1:0]                   full_i,
  input  pfb_pkg::slot_t               cur_i,
  input  logic [PTR_W-1:0]             off_i,
  input  logic                         spec_i,
  output logic [WIN_BYTES*8-1:0]       bytes_o,
  output logic [WIN_BYTES-1:0]         mask_o,
  output logic [TAKE_W-1:0]            count_o
);
  logic                    oth;
  logic [LINE_BYTES*8-1:0] cdat, ndat;
  logic [PTR_W:0]          pos;
  logic [OFF_W-1:0]        idx;

  always_comb begin
    oth     = ~cur_i;
    cdat    = data_i[cur_i];
    ndat    = data_i[oth];
    bytes_o = '0;
    mask_o  = '0;
    pos     = '0;
    idx     = '0;
    for (int i = 0; i < WIN_BYTES; i++) begin
      pos = {1'b0, off_i} + (PTR_W+1)'(i);
      if (pos < (PTR_W+1)'(LINE_BYTES)) begin
        idx = OFF_W'(pos);
        bytes_o[i*8 +: 8] = cdat[int'(idx)*8 +: 8];
        mask_o[i]         = full_i[cur_i];
      end else begin
        idx = OFF_W'(pos - (PTR_W+1)'(LINE_BYTES));
        bytes_o[i*8 +: 8] = ndat[int'(idx)*8 +: 8];
        mask_o[i]         = full_i[cur_i] & full_i[oth] & ~spec_i;
      end
    end
    count_o = TAKE_W'($countones(mask_o));
  end
endmodule

// File: rtl/pfb_ctrl.sv
module pfb_ctrl #(
  parameter int LINE_BYTES = 32,
  parameter int WIN_BYTES  = 16,
  parameter int ADDR_W     = 32,
  parameter logic [ADDR_W-1:0] RESET_ADDR = '0,
  localparam int OFF_W  = $clog2(LINE_BYTES),
  localparam int LN_W   = ADDR_W - OFF_W,
  localparam int PTR_W  = OFF_W + 1,
  localparam int TAKE_W = $clog2(WIN_BYTES + 1)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   flush_i,
  input  logic [ADDR_W-1:0]      flush_addr_i,
  input  logic                   br_taken_i,
  input  logic [ADDR_W-1:0]      br_target_i,
  input  logic                   resolve_i,
  input  logic                   resolve_ok_i,
  input  logic [TAKE_W-1:0]      take_i,
  input  logic [TAKE_W-1:0]      avail_i,
  input  logic                   ic_valid_i,
  output logic [1:0][LN_W-1:0]   line_o,
  output logic [1:0]             full_o,
  output pfb_pkg::slot_t         cur_o,
  output logic [PTR_W-1:0]       off_o,
  output logic                   spec_o,
  output logic                   fill_en_o,
  output pfb_pkg::slot_t         fill_sel_o,
  output logic                   req_o,
  output logic [ADDR_W-1:0]      req_addr_o
);
  localparam logic [PTR_W:0] LINE_P = (PTR_W+1)'(LINE_BYTES);

  logic [1:0][LN_W-1:0] line_q, n_line;
  logic [1:0]           full_q, n_full;
  pfb_pkg::slot_t       cur_q, n_cur, oth, tslot;
  logic [PTR_W-1:0]     off_q, n_off;
  logic                 spec_q, n_spec;
  logic [OFF_W-1:0]     tgt_q, n_tgt;
  logic [TAKE_W-1:0]    eff;
  logic [PTR_W:0]       sum;
  logic                 res_act, br_acc;

  always_comb begin
    oth        = ~cur_q;
    fill_sel_o = full_q[cur_q] ? oth : cur_q;
    req_o      = ~full_q[0] | ~full_q[1];
    req_addr_o = {line_q[fill_sel_o], {OFF_W{1'b0}}};
    res_act    = resolve_i & spec_q;
    br_acc     = br_taken_i & ~spec_q;
    fill_en_o  = req_o & ic_valid_i & ~flush_i & ~res_act & ~br_acc;
    eff        = (take_i <= avail_i) ? take_i : '0;
    sum        = {1'b0, off_q} + (PTR_W+1)'(eff);

    n_line = line_q;
    n_full = full_q;
    n_cur  = cur_q;
    n_spec = spec_q;
    n_tgt  = tgt_q;
    tslot  = oth;
    if (fill_en_o) n_full[fill_sel_o] = 1'b1;
    if (!spec_q && sum >= LINE_P) begin
      n_full[cur_q] = 1'b0;
      n_line[cur_q] = line_q[oth] + LN_W'(1);
      n_cur         = oth;
      n_off         = PTR_W'(sum - LINE_P);
    end else begin
      n_off = PTR_W'(sum);
    end

    if (flush_i) begin
      n_cur     = pfb_pkg::SLOT_A;
      n_off     = {1'b0, flush_addr_i[OFF_W-1:0]};
      n_line[0] = flush_addr_i[ADDR_W-1:OFF_W];
      n_line[1] = flush_addr_i[ADDR_W-1:OFF_W] + LN_W'(1);
      n_full    = '0;
      n_spec    = 1'b0;
    end else if (res_act) begin
      n_spec = 1'b0;
      if (resolve_ok_i) begin
        n_full[cur_q] = 1'b0;
        n_line[cur_q] = line_q[oth] + LN_W'(1);
        n_cur         = oth;
        n_off         = {1'b0, tgt_q};
      end else if (n_off == PTR_W'(LINE_BYTES)) begin
        n_line[oth]   = line_q[cur_q] + LN_W'(1);
        n_line[cur_q] = line_q[cur_q] + LN_W'(2);
        n_full        = '0;
        n_cur         = oth;
        n_off         = '0;
      end else begin
        n_line[oth] = line_q[cur_q] + LN_W'(1);
        n_full[oth] = 1'b0;
      end
    end else if (br_acc) begin
      tslot         = ~n_cur;
      n_line[tslot] = br_target_i[ADDR_W-1:OFF_W];
      n_full[tslot] = 1'b0;
      n_tgt         = br_target_i[OFF_W-1:0];
      n_spec        = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      line_q[0] <= RESET_ADDR[ADDR_W-1:OFF_W];
      line_q[1] <= RESET_ADDR[ADDR_W-1:OFF_W] + LN_W'(1);
      full_q    <= '0;
      cur_q     <= pfb_pkg::SLOT_A;
      off_q     <= {1'b0, RESET_ADDR[OFF_W-1:0]};
      spec_q    <= 1'b0;
      tgt_q     <= '0;
    end else begin
      line_q <= n_line;
      full_q <= n_full;
      cur_q  <= n_cur;
      off_q  <= n_off;
      spec_q <= n_spec;
      tgt_q  <= n_tgt;
    end
  end

  assign line_o = line_q;
  assign full_o = full_q;
  assign cur_o  = cur_q;
  assign off_o  = off_q;
  assign spec_o = spec_q;

  // R4: while a target is pending the read slot never changes on its own
  assert_spec_holds_slot_R4: assert property (@(posedge clk) disable iff (rst)
    spec_q && !flush_i && !resolve_i |=> cur_q == $past(cur_q));

  // R2: an outstanding request is held until served
  assert_req_held_R2: assert property (@(posedge clk) disable iff (rst)
    req_o && !ic_valid_i |=> req_o);
endmodule

// File: rtl/prefetch_dual_buf.sv
module prefetch_dual_buf #(
  parameter int LINE_BYTES = 32,
  parameter int WIN_BYTES  = 16,
  parameter int ADDR_W     = 32,
  parameter logic [ADDR_W-1:0] RESET_ADDR = '0,
  localparam int OFF_W  = $clog2(LINE_BYTES),
  localparam int LN_W   = ADDR_W - OFF_W,
  localparam int PTR_W  = OFF_W + 1,
  localparam int TAKE_W = $clog2(WIN_BYTES + 1)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    flush_i,
  input  logic [ADDR_W-1:0]       flush_addr_i,
  input  logic                    br_taken_i,
  input  logic [ADDR_W-1:0]       br_target_i,
  input  logic                    resolve_i,
  input  logic                    resolve_ok_i,
  output logic                    ic_req_o,
  output logic [ADDR_W-1:0]       ic_addr_o,
  input  logic                    ic_valid_i,
  input  logic [LINE_BYTES*8-1:0] ic_data_i,
  output logic [WIN_BYTES*8-1:0]  dec_bytes_o,
  output logic [WIN_BYTES-1:0]    dec_mask_o,
  output logic                    dec_valid_o,
  output logic [ADDR_W-1:0]       dec_pc_o,
  input  logic [TAKE_W-1:0]       dec_take_i
);
  logic [1:0][LN_W-1:0]         line;
  logic [1:0]                   full;
  pfb_pkg::slot_t               cur, fill_sel;
  logic [PTR_W-1:0]             off;
  logic                         spec, fill_en;
  logic [TAKE_W-1:0]            avail;
  logic [1:0][LINE_BYTES*8-1:0] data;

  pfb_ctrl #(.LINE_BYTES(LINE_BYTES), .WIN_BYTES(WIN_BYTES), .ADDR_W(ADDR_W),
             .RESET_ADDR(RESET_ADDR)) u_ctrl (
    .clk(clk), .rst(rst), .flush_i(flush_i), .flush_addr_i(flush_addr_i),
    .br_taken_i(br_taken_i), .br_target_i(br_target_i),
    .resolve_i(resolve_i), .resolve_ok_i(resolve_ok_i),
    .take_i(dec_take_i), .avail_i(avail), .ic_valid_i(ic_valid_i),
    .line_o(line), .full_o(full), .cur_o(cur), .off_o(off), .spec_o(spec),
    .fill_en_o(fill_en), .fill_sel_o(fill_sel),
    .req_o(ic_req_o), .req_addr_o(ic_addr_o));

  pfb_store #(.LINE_BYTES(LINE_BYTES)) u_store (
    .clk(clk), .we(fill_en), .wsel(fill_sel), .wdata(ic_data_i), .rdata(data));

  pfb_window #(.LINE_BYTES(LINE_BYTES), .WIN_BYTES(WIN_BYTES)) u_win (
    .data_i(data), .full_i(full), .cur_i(cur), .off_i(off), .spec_i(spec),
    .bytes_o(dec_bytes_o), .mask_o(dec_mask_o), .count_o(avail));

  assign dec_valid_o = dec_mask_o[0];
  assign dec_pc_o    = {line[cur], {OFF_W{1'b0}}} + ADDR_W'(off);

  // R5: accepted consumption moves the read address by exactly that count
  assert_pc_step_R5: assert property (@(posedge clk) disable iff (rst)
    !flush_i && !(resolve_i && spec) && (dec_take_i <= avail)
    |=> dec_pc_o == $past(dec_pc_o) + ADDR_W'($past(dec_take_i)));

  // R10: a flush lands on its address with an empty window
  assert_flush_restart_R10: assert property (@(posedge clk) disable iff (rst)
    flush_i |=> (dec_pc_o == $past(flush_addr_i)) && (dec_mask_o == '0));

  // R3: offered bytes form one run starting at byte 0
  assert_mask_contig_R3: assert property (@(posedge clk) disable iff (rst)
    ((dec_mask_o + WIN_BYTES'(1)) & dec_mask_o) == '0);
endmodule

// File: tb/test_prefetch_dual_buf.sv
module test_prefetch_dual_buf;
  localparam int LB = 32;
  localparam int WB = 16;
  localparam int AW = 32;
  localparam int TW = $clog2(WB + 1);

  logic clk = 0, rst = 1;
  logic flush = 0, br = 0, res = 0, res_ok = 0;
  logic [AW-1:0] fl_addr = 0, tgt = 0;
  logic ic_req, ic_valid = 0;
  logic [AW-1:0] ic_addr;
  logic [LB*8-1:0] ic_data = 0;
  logic [WB*8-1:0] dbytes;
  logic [WB-1:0] dmask;
  logic dvalid;
  logic [AW-1:0] dpc;
  logic [TW-1:0] take = 0;

  int total = 0, bad = 0;
  int consumed = 0;
  bit cache_on = 0, cache_rnd = 0;
  logic [AW-1:0] m_pc = 0, m_tgt = 0;
  bit m_spec = 0;

  always #10 clk = ~clk;

  prefetch_dual_buf i_prefetch_dual_buf (
    .clk(clk), .rst(rst), .flush_i(flush), .flush_addr_i(fl_addr),
    .br_taken_i(br), .br_target_i(tgt), .resolve_i(res), .resolve_ok_i(res_ok),
    .ic_req_o(ic_req), .ic_addr_o(ic_addr), .ic_valid_i(ic_valid), .ic_data_i(ic_data),
    .dec_bytes_o(dbytes), .dec_mask_o(dmask), .dec_valid_o(dvalid),
    .dec_pc_o(dpc), .dec_take_i(take));

  function automatic logic [7:0] fb(input logic [AW-1:0] a);
    return (a[7:0] * 8'd29) ^ a[15:8] ^ a[23:16] ^ 8'h5A;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_stream();
    chk(dpc == m_pc, "R5 read address", dpc, m_pc);
    chk(dvalid == dmask[0], "R3 valid flag", dvalid, dmask[0]);
    chk(((dmask + 16'd1) & dmask) == 0, "R3 mask run", dmask, 0);
    for (int i = 0; i < WB; i++) begin
      if (dmask[i])
        chk(dbytes[i*8 +: 8] == fb(dpc + i), "R3 byte value", dbytes[i*8 +: 8], fb(dpc + i));
      if (m_spec && (((m_pc + i) >> 5) != (m_pc >> 5)))
        chk(!dmask[i], "R4 R7 no crossing while target pending", dmask[i], 0);
    end
  endtask

  task automatic tick();
    int cnt;
    logic [TW-1:0] eff;
    ic_valid = ic_req & (cache_rnd ? 1'($urandom % 2) : cache_on);
    for (int k = 0; k < LB; k++) ic_data[k*8 +: 8] = fb(ic_addr + k);
    cnt = $countones(dmask);
    eff = (int'(take) <= cnt) ? take : 0;
    if (flush) begin
      m_pc = fl_addr; m_spec = 0;
    end else begin
      m_pc = m_pc + eff;
      consumed += eff;
      if (m_spec && res) begin
        m_spec = 0;
        if (res_ok) m_pc = m_tgt;
      end else if (!m_spec && br) begin
        m_spec = 1; m_tgt = tgt;
      end
    end
    @(negedge clk);
    check_stream();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst = 0;
    chk(dvalid == 0, "R1 valid after reset", dvalid, 0);
    chk(dmask == 0, "R1 mask after reset", dmask, 0);
    chk(dpc == 0, "R1 address after reset", dpc, 0);
    chk(ic_req == 1 && ic_addr == 0, "R1 first request", ic_addr, 0);

    // partial line next to the end, next line absent
    flush = 1; fl_addr = 32'h11C; tick(); flush = 0;
    chk(ic_addr == 32'h100 && ic_req, "R10 R2 flush line requested", ic_addr, 32'h100);
    chk(dmask == 0, "R10 empty after flush", dmask, 0);
    cache_on = 1; tick(); cache_on = 0;
    chk(dmask == 16'h000F, "R4 no join before next line", dmask, 16'h000F);
    chk(ic_addr == 32'h120, "R2 spare requested second", ic_addr, 32'h120);
    cache_on = 1; tick(); cache_on = 0;
    chk(dmask == 16'hFFFF, "R4 join once next stored", dmask, 16'hFFFF);
    chk(ic_req == 0, "R2 no request when both full", ic_req, 0);
    take = 4; tick(); take = 0;
    chk(dpc == 32'h120, "R5 cross into next", dpc, 32'h120);
    chk(ic_addr == 32'h140 && ic_req, "R6 emptied slot refetches", ic_addr, 32'h140);

    // predicted branch, drain current line
    br = 1; tgt = 32'h205; tick(); br = 0;
    chk(ic_addr == 32'h200, "R7 target line requested", ic_addr, 32'h200);
    take = 16; tick(); tick(); take = 0;
    chk(dpc == 32'h140 && dmask == 0, "R7 stops at line end", dmask, 0);
    br = 1; tgt = 32'h300; tick(); br = 0;
    chk(ic_addr == 32'h200, "R7 second branch ignored", ic_addr, 32'h200);
    cache_on = 1; tick(); cache_on = 0;
    res = 1; res_ok = 1; tick(); res = 0;
    chk(dpc == 32'h205, "R8 correct goes to target", dpc, 32'h205);
    chk(dmask == 16'hFFFF, "R8 target bytes offered", dmask, 16'hFFFF);
    chk(ic_addr == 32'h220, "R8 sequential after target", ic_addr, 32'h220);

    // wrong prediction
    flush = 1; fl_addr = 32'h400; cache_on = 1; tick(); flush = 0;
    tick(); tick(); cache_on = 0;
    br = 1; tgt = 32'h505; tick(); br = 0;
    chk(ic_addr == 32'h500, "R7 target requested", ic_addr, 32'h500);
    res = 1; res_ok = 0; tick(); res = 0;
    chk(dpc == 32'h400, "R9 address kept on wrong", dpc, 32'h400);
    chk(ic_addr == 32'h420 && ic_req, "R9 sequential refetch", ic_addr, 32'h420);
    cache_on = 1; tick(); cache_on = 0;
    chk(dmask == 16'hFFFF, "R9 sequential joined", dmask, 16'hFFFF);
    res = 1; res_ok = 1; tick(); res = 0;
    chk(dpc == 32'h400, "R9 resolve without target ignored", dpc, 32'h400);

    // consumption with branch in the same cycle
    br = 1; tgt = 32'h600; take = 8; tick(); br = 0; take = 0;
    chk(dpc == 32'h408, "R11 consume on branch cycle", dpc, 32'h408);
    res = 1; res_ok = 1; tick(); res = 0;
    chk(dpc == 32'h600, "R8 target address", dpc, 32'h600);

    // oversize consume
    flush = 1; fl_addr = 32'h700; tick(); flush = 0;
    take = 5; tick(); take = 0;
    chk(dpc == 32'h700, "R5 oversize take ignored", dpc, 32'h700);

    // flush wins over branch
    flush = 1; fl_addr = 32'h800; br = 1; tgt = 32'h900; tick(); flush = 0; br = 0;
    cache_on = 1; tick(); tick(); cache_on = 0;
    res = 1; res_ok = 1; tick(); res = 0;
    chk(dpc == 32'h800, "R10 flush beats branch", dpc, 32'h800);

    // random traffic
    cache_rnd = 1;
    for (int n = 0; n < 20000; n++) begin
      int cnt;
      cnt = $countones(dmask);
      flush = ($urandom % 64) == 0; fl_addr = $urandom;
      br = ($urandom % 12) == 0; tgt = $urandom;
      res = ($urandom % 10) == 0; res_ok = 1'($urandom % 2);
      if (($urandom % 5) == 0) take = TW'($urandom % 17);
      else take = TW'($urandom % (cnt + 1));
      tick();
    end
    flush = 0; br = 0; res = 0; take = 0;
    chk(consumed > 2000, "R5 R6 stream progresses", consumed, 2000);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule